// File: doc/BRIEF.md
# Self-Checking Carry-Select Adder

This block adds two unsigned operands and a carry in, and at the same time reports whether its own internal arithmetic is consistent. The datapath is cut into 4-bit slices. Each slice holds two independent ripple adders. One assumes the slice carry in is 0 and the other assumes it is 1. The true carry arriving from the slice below chooses which precomputed sum and carry the slice passes upward.

Because the two adders of a slice always see the same operands, the result on the carry-1 side must equal the result on the carry-0 side plus one. Each slice turns that relation into dual-rail pairs. A pair is healthy only when its two bits differ. A linear cascade of two-pair two-rail checker cells folds every pair into one error pair, and a single error bit is derived from that pair.

The block is purely combinational. A fault-inject mask can flip any precomputed sum bit on either side, so the detection path can be exercised without altering the adder logic.

Top module: `scsa_adder`

## Requirements
- R1: With the inject mask all zero, `{cout, sum}` equals `a + b + cin` taken over WIDTH+1 bits.
- R2: With the inject mask all zero, `err_pair` is 2'b01 or 2'b10 and `err` is 0, for every operand pair and carry in.
- R3: Setting any bit of `inj_mask[WIDTH-1:0]` flips the matching sum bit of the carry-0 adder in that slice and drives `err` to 1. When the carry-0 side is selected, the flipped bit appears on `sum`.
- R4: Setting any bit of `inj_mask[2*WIDTH-1:WIDTH]` flips sum bit (index − WIDTH) of the carry-1 adder in that slice and drives `err` to 1. When the carry-1 side is selected, the flipped bit appears on `sum`.
- R5: A fault injected only on the side that a slice does not select leaves `sum` and `cout` at the correct value, yet still drives `err` to 1.
- R6: `err` is 1 exactly when `err_pair` is 2'b00 or 2'b11.
- R7: A carry entering at bit 0 ripples through every slice select: with `a` all ones, `b` zero and `cin` 1, `sum` is zero and `cout` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| inj_mask | input | 2*WIDTH | Fault inject: low half flips carry-0 side sum bits, high half flips carry-1 side sum bits |
| sum | output | WIDTH | Selected sum |
| cout | output | 1 | Carry out of the top slice |
| err_pair | output | 2 | Dual-rail error indication; 01 or 10 means healthy |
| err | output | 1 | 1 when `err_pair` is not complementary |

## Verification
The bench aims at carry paths that span whole slices. These are all-ones plus carry, sign-bit overflow, and patterns that wrap a slice exactly at its boundary. A select wired to the wrong neighbour, or a carry taken from the wrong side, gives a sum that is off at a slice edge. Fault injections are placed on both the selected and the unselected side, in the lowest and the highest slice. A checker that only watched the selected side would miss the unselected-side flips. A broken checker cell would let an invalid pair collapse back into a healthy 01 or 10.

// File: rtl/scsa_pkg.sv
package scsa_pkg;

  localparam int SLICE_W = 4;
  // sum bits plus one carry relation per slice
  localparam int PAIRS_PER_SLICE = SLICE_W + 1;

  // bit 0 and bit 1 are the two rails; a healthy pair has them different
  typedef logic [1:0] rail_t;

  function automatic logic rail_ok(input rail_t p);
    return p[0] ^ p[1];
  endfunction

  // plain ripple adder of one slice, result carry in the top bit
  function automatic logic [SLICE_W:0] ripple(input logic [SLICE_W-1:0] x,
                                              input logic [SLICE_W-1:0] y,
                                              input logic               c);
    logic [SLICE_W:0] r;
    logic             k;
    k = c;
    for (int i = 0; i < SLICE_W; i++) begin
      r[i] = x[i] ^ y[i] ^ k;
      k    = (x[i] & y[i]) | (k & (x[i] ^ y[i]));
    end
    r[SLICE_W] = k;
    return r;
  endfunction

endpackage

// File: rtl/scsa_tr_cell.sv
module scsa_tr_cell
  import scsa_pkg::*;
(
  input  rail_t x,
  input  rail_t y,
  output rail_t z
);

  assign z[0] = (x[0] & y[0]) | (x[1] & y[1]);
  assign z[1] = (x[0] & y[1]) | (x[1] & y[0]);

  always_comb begin
    if (rail_ok(x) && rail_ok(y)) begin
      p_cell_pass_r2: assert (rail_ok(z))
        else $error("two-rail cell broke a healthy pair");
    end else begin
      p_cell_flag_r3: assert (!rail_ok(z))
        else $error("two-rail cell masked an invalid pair");
    end
  end

endmodule

// File: rtl/scsa_tr_tree.sv
module scsa_tr_tree
  import scsa_pkg::*;
#(
  parameter int N_PAIRS = 5
) (
  input  logic [2*N_PAIRS-1:0] pairs,
  output rail_t                z
);

  rail_t acc [N_PAIRS];

  assign acc[0] = pairs[1:0];

  for (genvar i = 1; i < N_PAIRS; i++) begin : g_cell
    scsa_tr_cell u_cell (
      .x (acc[i-1]),
      .y (pairs[2*i+1 -: 2]),
      .z (acc[i])
    );
  end

  assign z = acc[N_PAIRS-1];

endmodule

// File: rtl/scsa_slice.sv
module scsa_slice
  import scsa_pkg::*;
(
  input  logic [SLICE_W-1:0]           a,
  input  logic [SLICE_W-1:0]           b,
  input  logic                         cin,
  input  logic [SLICE_W-1:0]           inj0,
  input  logic [SLICE_W-1:0]           inj1,
  output logic [SLICE_W-1:0]           sum,
  output logic                         cout,
  output logic [2*PAIRS_PER_SLICE-1:0] pairs
);

  localparam logic [SLICE_W:0] ONE = (SLICE_W+1)'(1);

  logic [SLICE_W:0]   rail0, rail1, inc0;
  logic [SLICE_W-1:0] s0, s1;
  logic               c0, c1, c1_pred;

  // two speculative adders
  assign rail0 = ripple(a, b, 1'b0);
  assign rail1 = ripple(a, b, 1'b1);

  assign s0 = rail0[SLICE_W-1:0] ^ inj0;
  assign s1 = rail1[SLICE_W-1:0] ^ inj1;
  assign c0 = rail0[SLICE_W];
  assign c1 = rail1[SLICE_W];

  // carry-1 result predicted from the carry-0 result
  assign inc0    = {1'b0, s0} + ONE;
  assign c1_pred = c0 | inc0[SLICE_W];

  for (genvar i = 0; i < SLICE_W; i++) begin : g_sum_pair
    assign pairs[2*i]   = s1[i];
    assign pairs[2*i+1] = ~inc0[i];
  end
  assign pairs[2*SLICE_W]   = c1;
  assign pairs[2*SLICE_W+1] = ~c1_pred;

  // true carry picks the result
  assign sum  = cin ? s1 : s0;
  assign cout = cin ? c1 : c0;

  always_comb begin
    if (inj0 == '0 && inj1 == '0) begin
      p_rails_agree_r2: assert ({c1, s1} == ({c0, s0} + ONE))
        else $error("speculative adders disagree without injection");
    end
  end

endmodule

// File: rtl/scsa_adder.sv
module scsa_adder
  import scsa_pkg::*;
#(
  parameter int WIDTH = 24
) (
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  input  logic               cin,
  input  logic [2*WIDTH-1:0] inj_mask,
  output logic [WIDTH-1:0]   sum,
  output logic               cout,
  output logic [1:0]         err_pair,
  output logic               err
);

  localparam int SLICES  = WIDTH / SLICE_W;
  localparam int N_PAIRS = SLICES * PAIRS_PER_SLICE;
  localparam int PW      = 2 * PAIRS_PER_SLICE;

  logic [SLICES:0]      carry;
  logic [2*N_PAIRS-1:0] all_pairs;
  rail_t                tree_z;

  assign carry[0] = cin;

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    scsa_slice u_slice (
      .a     (a[s*SLICE_W +: SLICE_W]),
      .b     (b[s*SLICE_W +: SLICE_W]),
      .cin   (carry[s]),
      .inj0  (inj_mask[s*SLICE_W +: SLICE_W]),
      .inj1  (inj_mask[WIDTH + s*SLICE_W +: SLICE_W]),
      .sum   (sum[s*SLICE_W +: SLICE_W]),
      .cout  (carry[s+1]),
      .pairs (all_pairs[s*PW +: PW])
    );
  end

  assign cout = carry[SLICES];

  scsa_tr_tree #(.N_PAIRS(N_PAIRS)) u_tree (
    .pairs (all_pairs),
    .z     (tree_z)
  );

  assign err_pair = tree_z;
  assign err      = ~(tree_z[0] ^ tree_z[1]);

  always_comb begin
    if (inj_mask == '0) begin
      p_sum_r1: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
        else $error("sum mismatch");
      p_clean_r2: assert (!err)
        else $error("error raised without injection");
    end else begin
      p_inject_seen_r4: assert (err)
        else $error("injected fault not flagged");
    end
  end

endmodule

// File: tb/scsa_adder_bench.sv
module scsa_adder_bench;

  localparam int W = 24;

  typedef struct packed {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         ci;
    logic [W-1:0] s;
    logic         co;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{24'h000000, 24'h000000, 1'b0, 24'h000000, 1'b0},
    '{24'hFFFFFF, 24'h000000, 1'b1, 24'h000000, 1'b1},
    '{24'hFFFFFF, 24'hFFFFFF, 1'b1, 24'hFFFFFF, 1'b1},
    '{24'h123456, 24'h654321, 1'b0, 24'h777777, 1'b0},
    '{24'h800000, 24'h800000, 1'b0, 24'h000000, 1'b1},
    '{24'h0F0F0F, 24'h00F0F1, 1'b0, 24'h100000, 1'b0},
    '{24'hABCDEF, 24'h111111, 1'b1, 24'hBCDF01, 1'b0},
    '{24'h00000F, 24'h000001, 1'b0, 24'h000010, 1'b0}
  };

  logic           clk = 1'b0;
  logic           rst_n;
  logic [W-1:0]   a, b;
  logic           cin;
  logic [2*W-1:0] inj_mask;
  logic [W-1:0]   sum;
  logic           cout;
  logic [1:0]     err_pair;
  logic           err;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #4 clk = ~clk;

  scsa_adder #(.WIDTH(W)) u_scsa_adder (
    .a        (a),
    .b        (b),
    .cin      (cin),
    .inj_mask (inj_mask),
    .sum      (sum),
    .cout     (cout),
    .err_pair (err_pair),
    .err      (err)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb,
                       input logic vc, input logic [2*W-1:0] vm);
    @(posedge clk);
    a = va; b = vb; cin = vc; inj_mask = vm;
    @(negedge clk);
  endtask

  // R6: err must mirror a non-complementary pair
  task automatic check_pair_bit();
    check("R6 err vs err_pair", 64'(err), 64'(err_pair == 2'b00 || err_pair == 2'b11));
  endtask

  initial begin
    logic [31:0]  lf;
    logic [W:0]   exp_full;
    rst_n = 1'b0;
    a = '0; b = '0; cin = 1'b0; inj_mask = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: zero inputs give zero sum and a healthy pair (R1, R2)
    check("R1 reset sum", 64'(sum), 64'd0);
    check("R2 reset err", 64'(err), 64'd0);
    rst_n = 1'b1;

    // table of directed vectors (R1, R2)
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].a, VECS[i].b, VECS[i].ci, '0);
      check("R1 table sum",  64'(sum),  64'(VECS[i].s));
      check("R1 table cout", 64'(cout), 64'(VECS[i].co));
      check("R2 table err",  64'(err),  64'd0);
      check("R2 table pair", 64'(err_pair == 2'b01 || err_pair == 2'b10), 64'd1);
    end

    // pseudo-random operands (R1, R2)
    lf = 32'h1ACE_B00C;
    for (int i = 0; i < 300; i++) begin
      lf = lf * 32'd1664525 + 32'd1013904223;
      a  = lf[31:8];
      lf = lf * 32'd1664525 + 32'd1013904223;
      apply(a, lf[31:8], lf[3], '0);
      exp_full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
      check("R1 random sum",  64'({cout, sum}), 64'(exp_full));
      check("R2 random err",  64'(err), 64'd0);
    end

    // R7: carry crosses every slice
    apply({W{1'b1}}, '0, 1'b1, '0);
    check("R7 chain sum",  64'(sum),  64'd0);
    check("R7 chain cout", 64'(cout), 64'd1);

    // R3: carry-0 side flip, low slice selected on carry-0 side
    apply('0, '0, 1'b0, 48'h1 << 5);
    check("R3 low slice err", 64'(err), 64'd1);
    check("R3 low slice sum", 64'(sum), 64'h000020);
    check_pair_bit();

    // R3: carry-0 side flip in top slice
    apply('0, '0, 1'b0, 48'h1 << 20);
    check("R3 top slice err", 64'(err), 64'd1);
    check("R3 top slice sum", 64'(sum), 64'h100000);
    check_pair_bit();

    // R4: carry-1 side flip, selected by cin=1
    apply('0, '0, 1'b1, 48'h1 << 24);
    check("R4 selected err", 64'(err), 64'd1);
    check("R4 selected sum", 64'(sum), 64'h000000);
    check_pair_bit();

    // R4: carry-1 side flip in top slice, carry reaches it through all ones
    apply(24'h0FFFFF, '0, 1'b1, 48'h1 << 47);
    check("R4 top err", 64'(err), 64'd1);
    check("R4 top sum", 64'(sum), 64'h900000);

    // R5: flip on the carry-1 side while carry-0 side is selected
    apply(24'h000003, 24'h000004, 1'b0, 48'h1 << 26);
    check("R5 unselected sum",  64'(sum),  64'h000007);
    check("R5 unselected cout", 64'(cout), 64'd0);
    check("R5 unselected err",  64'(err),  64'd1);

    // R5: flip on the carry-0 side while carry-1 side is selected
    apply(24'h000003, 24'h000004, 1'b1, 48'h1 << 1);
    check("R5 unselected c0 sum", 64'(sum), 64'h000008);
    check("R5 unselected c0 err", 64'(err), 64'd1);
    check_pair_bit();

    // injection removed: flag clears (R2)
    apply(24'h000003, 24'h000004, 1'b1, '0);
    check("R2 clear err", 64'(err), 64'd0);
    check_pair_bit();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule